// File: doc/BRIEF.md
# Store Queue with Store-to-Load Forwarding

This block keeps the in-flight stores of an out-of-order core in program order. Each store is allocated with a sequence number. Its effective address, byte size and data word are filled in later, once the store executes. Stores are committed by sequence number and then written back one at a time, oldest first. An entry is given back only after its writeback completes, and it leaves the queue one cycle after that completion.

A load presents its sequence number, address and size and gets a combinational verdict in the same cycle. The block looks for the youngest written store that is older than the load and overlaps it. If that store covers the whole load, its data is returned, shifted and trimmed to the load. If it covers only part of a load and has not yet been written back, the load must wait. The block records the oldest such load and the store it waits on. If it covers only part of a load and has already been written back, the load goes to memory. If no store overlaps, the load also goes to memory. A load refused by memory is recorded as blocked. An uncacheable load that is not yet eligible to commit is sent back for rescheduling.

A squash removes every store younger than a given sequence number in a single cycle.

Top module: `store_fwd_queue`

## Requirements
- R1: Allocation fills entries in order and `allocIdx` names the slot the next store takes. `sqFull` is high while occupancy is at least DEPTH-1, and an allocation request made while `sqFull` is high is ignored.
- R2: A lookup only considers stores whose sequence number is strictly lower than the load's. Among those it takes the youngest store that overlaps the load. Entries whose data has not been written (size still zero) are passed over.
- R3: When the chosen store covers the whole load, `ldResult` is 1 (forward). `ldData` is then the store data shifted right by 8 × (load address mod store size) bits, with bytes at or above the load size cleared. Sizes are 1, 2, 4 or 8 bytes and naturally aligned.
- R4: When the chosen store overlaps the load only partly and has not completed writeback, `ldResult` is 2 (stall). On the next edge, `stalled` is set and records the store's and the load's sequence numbers.
- R5: While stalled, a further stalling load replaces the recorded load only if its sequence number is lower.
- R6: When the chosen store overlaps the load only partly but has completed writeback, `ldResult` is 0 (memory).
- R7: With no overlapping store, `ldResult` is 0 and `memReqValid` is high. If `memReady` is low, the load is recorded in `loadBlocked` and `blockedSeq`, unless an older blocked load is already held. `blkClear` clears the record.
- R8: An uncacheable load with `ldAtCommit` low gets `ldResult` 3 (reschedule with fault), and `memReqValid` stays low.
- R9: Commit marks stores with sequence numbers at or below `commitSeq`. `wbValid` offers the oldest store when it is committed and not yet complete. `wbDone` completes it, and the entry stays visible to lookups until the following edge, when it is released. Commit alone frees nothing.
- R10: The stall clears on the edge where the recorded stalling store completes writeback.
- R11: A squash removes in one cycle every store younger than `squashSeq` and rewinds `allocIdx`. It also clears the stall if the recorded load is younger than `squashSeq`.
- R12: After reset the queue is empty, `allocIdx` is 0, and `stalled`, `loadBlocked` and `wbValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Allocate a store entry |
| allocSeq | input | SEQ_W | Sequence number of the new store |
| allocIdx | output | log2(DEPTH) | Slot the next allocation takes |
| sqFull | output | 1 | Occupancy has reached DEPTH-1 |
| wrValid | input | 1 | Write address, size and data into an entry |
| wrIdx | input | log2(DEPTH) | Entry to write |
| wrAddr | input | ADDR_W | Store effective address |
| wrSize | input | 4 | Store size in bytes |
| wrData | input | DATA_W | Store data |
| commitValid | input | 1 | Commit stores up to `commitSeq` |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| wbValid | output | 1 | Oldest store is ready for writeback |
| wbAddr | output | ADDR_W | Writeback address |
| wbSize | output | 4 | Writeback size in bytes |
| wbData | output | DATA_W | Writeback data |
| wbDone | input | 1 | Offered writeback has completed |
| squashValid | input | 1 | Squash younger stores |
| squashSeq | input | SEQ_W | Stores above this sequence number are removed |
| ldValid | input | 1 | Load lookup present |
| ldSeq | input | SEQ_W | Load sequence number |
| ldAddr | input | ADDR_W | Load address |
| ldSize | input | 4 | Load size in bytes |
| ldUncache | input | 1 | Load is uncacheable |
| ldAtCommit | input | 1 | Load is the oldest load and ready to commit |
| ldResult | output | 2 | 0 memory, 1 forward, 2 stall, 3 reschedule |
| ldData | output | DATA_W | Forwarded data |
| memReqValid | output | 1 | Load is issued to memory |
| memReady | input | 1 | Memory accepts the load |
| stalled | output | 1 | A partial-overlap stall is pending |
| stallStoreSeq | output | SEQ_W | Store the stall waits on |
| stallLoadSeq | output | SEQ_W | Oldest stalled load |
| loadBlocked | output | 1 | A load was refused by memory |
| blockedSeq | output | SEQ_W | Sequence number of the blocked load |
| blkClear | input | 1 | Clear the blocked-load record |

## Verification
The assertions rely on a few properties of the input stream:
- Sequence numbers grow with program order and never wrap.
- Stores are allocated in increasing sequence order.
- `squashSeq` never falls below a committed store.
- Writes target live entries with aligned addresses and sizes of 1, 2, 4 or 8 bytes.

The directed stimulus respects all of these. It uses small, increasing sequence numbers, aligned addresses and legal sizes. It never drives squash, allocation and completion in the same cycle. It inspects the completed-but-not-released window only combinationally, before the next edge.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  typedef enum logic [1:0] {
    LD_MEMORY  = 2'd0,
    LD_FORWARD = 2'd1,
    LD_STALL   = 2'd2,
    LD_RESCHED = 2'd3
  } ldOutcome_e;

  typedef enum logic [1:0] {
    HIT_NONE      = 2'd0,
    HIT_FULL      = 2'd1,
    HIT_PART_PEND = 2'd2,
    HIT_PART_DONE = 2'd3
  } hitKind_e;

  typedef struct packed {
    logic allocEn;
    logic completeEn;
    logic releaseEn;
    logic squashEn;
  } sqStrobe_t;

endpackage

// File: rtl/sfq_entries.sv
module sfq_entries
  import sfq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int NBYTES = DATA_W / 8,
  localparam int BIDX_W = $clog2(NBYTES),
  localparam int SIZE_W = BIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sqStrobe_t         strobe,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [SEQ_W-1:0]  allocSeq,
  input  logic              wrValid,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [DATA_W-1:0] wrData,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic [SEQ_W-1:0]  ldSeq,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [SIZE_W-1:0] ldSize,
  output logic              headValid,
  output logic              headCommitted,
  output logic              headCompleted,
  output logic [SEQ_W-1:0]  headSeq,
  output logic [ADDR_W-1:0] headAddr,
  output logic [SIZE_W-1:0] headSize,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  youngerCnt,
  output hitKind_e          hitKind,
  output logic [SEQ_W-1:0]  hitSeq,
  output logic [DATA_W-1:0] hitData
);

  logic [DEPTH-1:0]  eValid, eCommitted, eCompleted;
  logic [SEQ_W-1:0]  eSeq  [DEPTH];
  logic [ADDR_W-1:0] eAddr [DEPTH];
  logic [SIZE_W-1:0] eSize [DEPTH];
  logic [DATA_W-1:0] eData [DEPTH];

  // Entry storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eValid     <= '0;
      eCommitted <= '0;
      eCompleted <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        eSeq[i]  <= '0;
        eAddr[i] <= '0;
        eSize[i] <= '0;
        eData[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (commitValid && eValid[i] && eSeq[i] <= commitSeq)
          eCommitted[i] <= 1'b1;
        if (strobe.squashEn && eValid[i] && eSeq[i] > squashSeq)
          eValid[i] <= 1'b0;
      end
      if (wrValid && eValid[wrIdx]) begin
        eAddr[wrIdx] <= wrAddr;
        eSize[wrIdx] <= wrSize;
        eData[wrIdx] <= wrData;
      end
      if (strobe.completeEn) eCompleted[headPtr] <= 1'b1;
      if (strobe.releaseEn)  eValid[headPtr]     <= 1'b0;
      if (strobe.allocEn) begin
        eValid[tailPtr]     <= 1'b1;
        eCommitted[tailPtr] <= 1'b0;
        eCompleted[tailPtr] <= 1'b0;
        eSeq[tailPtr]       <= allocSeq;
        eSize[tailPtr]      <= '0;
      end
    end
  end

  assign headValid     = eValid[headPtr];
  assign headCommitted = eCommitted[headPtr];
  assign headCompleted = eCompleted[headPtr];
  assign headSeq       = eSeq[headPtr];
  assign headAddr      = eAddr[headPtr];
  assign headSize      = eSize[headPtr];
  assign headData      = eData[headPtr];

  // Count of entries a squash would remove
  always_comb begin
    youngerCnt = '0;
    for (int i = 0; i < DEPTH; i++)
      youngerCnt = youngerCnt + CNT_W'(eValid[i] && eSeq[i] > squashSeq);
  end

  // Load-side byte mask
  logic [DATA_W-1:0] loadMask;
  always_comb begin
    for (int b = 0; b < NBYTES; b++)
      loadMask[b*8 +: 8] = (SIZE_W'(b) < ldSize) ? 8'hFF : 8'h00;
  end

  logic [ADDR_W:0] ldLo, ldHi;
  assign ldLo = {1'b0, ldAddr};
  assign ldHi = ldLo + {{(ADDR_W+1-SIZE_W){1'b0}}, ldSize};

  // Per-age compare slices; age 0 is the oldest entry
  logic [DEPTH-1:0]  cand, ovl, cont, ageDone;
  logic [SEQ_W-1:0]  ageSeq     [DEPTH];
  logic [DATA_W-1:0] ageShifted [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    logic [PTR_W-1:0]    idx;
    logic [ADDR_W:0]     stLo, stHi;
    logic [SIZE_W-1:0]   sizeM1;
    logic [BIDX_W+2:0]   shiftBits;
    assign idx       = headPtr + PTR_W'(k);
    assign stLo      = {1'b0, eAddr[idx]};
    assign stHi      = stLo + {{(ADDR_W+1-SIZE_W){1'b0}}, eSize[idx]};
    assign sizeM1    = eSize[idx] - SIZE_W'(1);
    assign shiftBits = {ldAddr[BIDX_W-1:0] & sizeM1[BIDX_W-1:0], 3'b000};
    assign cand[k]   = eValid[idx] && (eSeq[idx] < ldSeq) && (eSize[idx] != '0);
    assign ovl[k]    = (ldLo < stHi) && (ldHi > stLo);
    assign cont[k]   = (ldLo >= stLo) && (ldHi <= stHi);
    assign ageDone[k]    = eCompleted[idx];
    assign ageSeq[k]     = eSeq[idx];
    assign ageShifted[k] = eData[idx] >> shiftBits;
  end

  // Youngest-first priority pick
  logic found;
  always_comb begin
    found   = 1'b0;
    hitKind = HIT_NONE;
    hitSeq  = '0;
    hitData = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (!found && cand[k] && ovl[k]) begin
        found  = 1'b1;
        hitSeq = ageSeq[k];
        if (cont[k]) begin
          hitKind = HIT_FULL;
          hitData = ageShifted[k] & loadMask;
        end else if (ageDone[k]) begin
          hitKind = HIT_PART_DONE;
        end else begin
          hitKind = HIT_PART_PEND;
        end
      end
    end
  end

  // R2: any reported hit comes from a store older than the load
  a_r2_hit_is_older: assert property (@(posedge clk) disable iff (!rst_n)
    (hitKind != HIT_NONE) |-> (hitSeq < ldSeq));

endmodule

// File: rtl/sfq_ctrl.sv
module sfq_ctrl
  import sfq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocValid,
  input  logic              wbDone,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              headValid,
  input  logic              headCommitted,
  input  logic              headCompleted,
  input  logic [SEQ_W-1:0]  headSeq,
  input  logic [CNT_W-1:0]  youngerCnt,
  input  logic              ldValid,
  input  logic [SEQ_W-1:0]  ldSeq,
  input  logic              ldUncache,
  input  logic              ldAtCommit,
  input  hitKind_e          hitKind,
  input  logic [SEQ_W-1:0]  hitSeq,
  input  logic              memReady,
  input  logic              blkClear,
  output sqStrobe_t         strobe,
  output logic [PTR_W-1:0]  headPtr,
  output logic [PTR_W-1:0]  tailPtr,
  output logic              sqFull,
  output logic              wbValid,
  output ldOutcome_e        ldResult,
  output logic              memReqValid,
  output logic              stalled,
  output logic [SEQ_W-1:0]  stallStoreSeq,
  output logic [SEQ_W-1:0]  stallLoadSeq,
  output logic              loadBlocked,
  output logic [SEQ_W-1:0]  blockedSeq
);

  logic [CNT_W-1:0] count, survivors;

  assign sqFull  = count >= CNT_W'(DEPTH - 1);
  assign wbValid = headValid && headCommitted && !headCompleted;

  always_comb begin
    strobe.allocEn    = allocValid && !sqFull && !squashValid;
    strobe.completeEn = wbDone && wbValid;
    strobe.releaseEn  = headValid && headCompleted;
    strobe.squashEn   = squashValid;
  end

  assign survivors = count - youngerCnt;

  // Pointer and occupancy bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      headPtr <= headPtr + PTR_W'(strobe.releaseEn);
      if (strobe.squashEn) begin
        tailPtr <= headPtr + survivors[PTR_W-1:0];
        count   <= survivors - CNT_W'(strobe.releaseEn);
      end else begin
        tailPtr <= tailPtr + PTR_W'(strobe.allocEn);
        count   <= count + CNT_W'(strobe.allocEn) - CNT_W'(strobe.releaseEn);
      end
    end
  end

  // Load verdict
  always_comb begin
    if (ldUncache && !ldAtCommit) begin
      ldResult = LD_RESCHED;
    end else begin
      case (hitKind)
        HIT_FULL:      ldResult = LD_FORWARD;
        HIT_PART_PEND: ldResult = LD_STALL;
        default:       ldResult = LD_MEMORY;
      endcase
    end
  end

  assign memReqValid = ldValid && (ldResult == LD_MEMORY);

  // Stall owner tracking
  logic stallEvent, stallClr;
  assign stallEvent = ldValid && (ldResult == LD_STALL);
  assign stallClr   = stalled &&
                      ((strobe.completeEn && headSeq == stallStoreSeq) ||
                       (strobe.squashEn && stallLoadSeq > squashSeq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stalled       <= 1'b0;
      stallStoreSeq <= '0;
      stallLoadSeq  <= '0;
    end else begin
      if (stallClr) stalled <= 1'b0;
      if (stallEvent && (!stalled || stallClr || ldSeq < stallLoadSeq)) begin
        stalled       <= 1'b1;
        stallStoreSeq <= hitSeq;
        stallLoadSeq  <= ldSeq;
      end
    end
  end

  // Blocked-load tracking
  logic blkEvent;
  assign blkEvent = memReqValid && !memReady;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadBlocked <= 1'b0;
      blockedSeq  <= '0;
    end else begin
      if (blkClear) loadBlocked <= 1'b0;
      if (blkEvent && (!loadBlocked || blkClear || ldSeq < blockedSeq)) begin
        loadBlocked <= 1'b1;
        blockedSeq  <= ldSeq;
      end
    end
  end

  // R1: no growth while full
  a_r1_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (sqFull && !squashValid) |=> (count <= $past(count)));

  // R5: recorded stalling load only moves to older loads
  a_r5_stall_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (stalled && $past(stalled) && !$past(stallClr)) |-> (stallLoadSeq <= $past(stallLoadSeq)));

  // R7: recorded blocked load only moves to older loads
  a_r7_block_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (loadBlocked && $past(loadBlocked) && !$past(blkClear)) |-> (blockedSeq <= $past(blockedSeq)));

  // R8: ineligible uncacheable loads never reach memory
  a_r8_uncache_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (ldValid && ldUncache && !ldAtCommit) |-> !memReqValid);

  // R9: an entry is released only on the edge after its completion
  a_r9_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.releaseEn |-> $past(strobe.completeEn));

endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sfq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = PTR_W + 1,
  localparam int SIZE_W = $clog2(DATA_W / 8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allocValid,
  input  logic [SEQ_W-1:0]  allocSeq,
  output logic [PTR_W-1:0]  allocIdx,
  output logic              sqFull,
  input  logic              wrValid,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [DATA_W-1:0] wrData,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [SIZE_W-1:0] wbSize,
  output logic [DATA_W-1:0] wbData,
  input  logic              wbDone,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              ldValid,
  input  logic [SEQ_W-1:0]  ldSeq,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [SIZE_W-1:0] ldSize,
  input  logic              ldUncache,
  input  logic              ldAtCommit,
  output logic [1:0]        ldResult,
  output logic [DATA_W-1:0] ldData,
  output logic              memReqValid,
  input  logic              memReady,
  output logic              stalled,
  output logic [SEQ_W-1:0]  stallStoreSeq,
  output logic [SEQ_W-1:0]  stallLoadSeq,
  output logic              loadBlocked,
  output logic [SEQ_W-1:0]  blockedSeq,
  input  logic              blkClear
);

  sqStrobe_t        strobe;
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic             headValid, headCommitted, headCompleted;
  logic [SEQ_W-1:0] headSeq, hitSeq;
  logic [CNT_W-1:0] youngerCnt;
  hitKind_e         hitKind;
  ldOutcome_e       outcome;

  sfq_entries #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_entries (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .headPtr       (headPtr),
    .tailPtr       (tailPtr),
    .allocSeq      (allocSeq),
    .wrValid       (wrValid),
    .wrIdx         (wrIdx),
    .wrAddr        (wrAddr),
    .wrSize        (wrSize),
    .wrData        (wrData),
    .commitValid   (commitValid),
    .commitSeq     (commitSeq),
    .squashSeq     (squashSeq),
    .ldSeq         (ldSeq),
    .ldAddr        (ldAddr),
    .ldSize        (ldSize),
    .headValid     (headValid),
    .headCommitted (headCommitted),
    .headCompleted (headCompleted),
    .headSeq       (headSeq),
    .headAddr      (wbAddr),
    .headSize      (wbSize),
    .headData      (wbData),
    .youngerCnt    (youngerCnt),
    .hitKind       (hitKind),
    .hitSeq        (hitSeq),
    .hitData       (ldData)
  );

  sfq_ctrl #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .allocValid    (allocValid),
    .wbDone        (wbDone),
    .squashValid   (squashValid),
    .squashSeq     (squashSeq),
    .headValid     (headValid),
    .headCommitted (headCommitted),
    .headCompleted (headCompleted),
    .headSeq       (headSeq),
    .youngerCnt    (youngerCnt),
    .ldValid       (ldValid),
    .ldSeq         (ldSeq),
    .ldUncache     (ldUncache),
    .ldAtCommit    (ldAtCommit),
    .hitKind       (hitKind),
    .hitSeq        (hitSeq),
    .memReady      (memReady),
    .blkClear      (blkClear),
    .strobe        (strobe),
    .headPtr       (headPtr),
    .tailPtr       (tailPtr),
    .sqFull        (sqFull),
    .wbValid       (wbValid),
    .ldResult      (outcome),
    .memReqValid   (memReqValid),
    .stalled       (stalled),
    .stallStoreSeq (stallStoreSeq),
    .stallLoadSeq  (stallLoadSeq),
    .loadBlocked   (loadBlocked),
    .blockedSeq    (blockedSeq)
  );

  assign allocIdx = tailPtr;
  assign ldResult = outcome;

endmodule

// File: tb/store_fwd_queue_bench.sv
module store_fwd_queue_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        allocValid = 0;
  logic [15:0] allocSeq = 0;
  logic [2:0]  allocIdx;
  logic        sqFull;
  logic        wrValid = 0;
  logic [2:0]  wrIdx = 0;
  logic [31:0] wrAddr = 0;
  logic [3:0]  wrSize = 0;
  logic [63:0] wrData = 0;
  logic        commitValid = 0;
  logic [15:0] commitSeq = 0;
  logic        wbValid;
  logic [31:0] wbAddr;
  logic [3:0]  wbSize;
  logic [63:0] wbData;
  logic        wbDone = 0;
  logic        squashValid = 0;
  logic [15:0] squashSeq = 0;
  logic        ldValid = 0;
  logic [15:0] ldSeq = 0;
  logic [31:0] ldAddr = 0;
  logic [3:0]  ldSize = 0;
  logic        ldUncache = 0;
  logic        ldAtCommit = 0;
  logic [1:0]  ldResult;
  logic [63:0] ldData;
  logic        memReqValid;
  logic        memReady = 1;
  logic        stalled;
  logic [15:0] stallStoreSeq, stallLoadSeq;
  logic        loadBlocked;
  logic [15:0] blockedSeq;
  logic        blkClear = 0;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  store_fwd_queue u_store_fwd_queue (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doAlloc(input logic [15:0] s);
    allocValid = 1; allocSeq = s; step(); allocValid = 0;
  endtask

  task automatic doWrite(input logic [2:0] i, input logic [31:0] a, input logic [3:0] sz,
                         input logic [63:0] d);
    wrValid = 1; wrIdx = i; wrAddr = a; wrSize = sz; wrData = d; step(); wrValid = 0;
  endtask

  task automatic doSquash(input logic [15:0] s);
    squashValid = 1; squashSeq = s; step(); squashValid = 0;
  endtask

  task automatic setLoad(input logic [15:0] s, input logic [31:0] a, input logic [3:0] sz);
    ldValid = 1; ldSeq = s; ldAddr = a; ldSize = sz; #1;
  endtask

  task automatic dropLoad();
    ldValid = 0; ldUncache = 0; ldAtCommit = 0; memReady = 1;
  endtask

  task automatic testReset();
    chk("R12 allocIdx", allocIdx, 0);
    chk("R12 sqFull", sqFull, 0);
    chk("R12 stalled", stalled, 0);
    chk("R12 loadBlocked", loadBlocked, 0);
    chk("R12 wbValid", wbValid, 0);
  endtask

  task automatic testFull();
    for (int n = 0; n < 6; n++) doAlloc(16'(10 + n));
    chk("R1 not full at 6", sqFull, 0);
    doAlloc(16'd16);
    chk("R1 full at 7", sqFull, 1);
    chk("R1 allocIdx at 7", allocIdx, 7);
    doAlloc(16'd17);
    chk("R1 alloc ignored when full", allocIdx, 7);
    doSquash(16'd0);
    chk("R11 squash empties", allocIdx, 0);
    chk("R11 not full after squash", sqFull, 0);
  endtask

  task automatic testForward();
    doAlloc(16'd10); doWrite(3'd0, 32'h100, 4'd8, 64'h1122334455667788);
    doAlloc(16'd20); doWrite(3'd1, 32'h108, 4'd4, 64'h00000000AABBCCDD);
    setLoad(16'd30, 32'h104, 4'd2);
    chk("R3 forward code", ldResult, 1);
    chk("R3 forward shifted data", ldData, 64'h3344);
    dropLoad();
    setLoad(16'd15, 32'h108, 4'd4);
    chk("R2 younger store ignored", ldResult, 0);
    chk("R7 memReqValid", memReqValid, 1);
    dropLoad();
    setLoad(16'd30, 32'h10A, 4'd2);
    chk("R3 forward upper half", ldData, 64'hAABB);
    dropLoad();
    doAlloc(16'd25); doWrite(3'd2, 32'h100, 4'd1, 64'h5A);
    setLoad(16'd30, 32'h100, 4'd1);
    chk("R2 youngest older store wins", ldData, 64'h5A);
    dropLoad();
    doAlloc(16'd27);
    setLoad(16'd30, 32'h100, 4'd1);
    chk("R2 unwritten entry skipped", ldData, 64'h5A);
    dropLoad();
    doSquash(16'd0);
  endtask

  task automatic testStall();
    doAlloc(16'd10); doWrite(3'd0, 32'h200, 4'd2, 64'hBEEF);
    setLoad(16'd50, 32'h200, 4'd4);
    chk("R4 stall code", ldResult, 2);
    step(); dropLoad();
    chk("R4 stalled set", stalled, 1);
    chk("R4 stall store seq", stallStoreSeq, 10);
    chk("R4 stall load seq", stallLoadSeq, 50);
    setLoad(16'd40, 32'h200, 4'd4); step(); dropLoad();
    chk("R5 older load replaces", stallLoadSeq, 40);
    setLoad(16'd45, 32'h200, 4'd4); step(); dropLoad();
    chk("R5 younger load kept out", stallLoadSeq, 40);
    commitValid = 1; commitSeq = 16'd10; step(); commitValid = 0;
    chk("R9 wbValid after commit", wbValid, 1);
    chk("R9 wbAddr", wbAddr, 32'h200);
    setLoad(16'd50, 32'h200, 4'd2);
    chk("R9 commit does not free", ldData, 64'hBEEF);
    dropLoad();
    wbDone = 1; step(); wbDone = 0;
    chk("R10 stall cleared on completion", stalled, 0);
    chk("R9 wbValid low once complete", wbValid, 0);
    setLoad(16'd50, 32'h200, 4'd4);
    chk("R6 completed partial goes to memory", ldResult, 0);
    ldSize = 4'd2; #1;
    chk("R9 completed entry still visible", ldResult, 1);
    dropLoad();
    step();
    setLoad(16'd50, 32'h200, 4'd2);
    chk("R9 entry released after completion", ldResult, 0);
    dropLoad();
    chk("R9 allocIdx after release", allocIdx, 1);
  endtask

  task automatic testBlocked();
    memReady = 0;
    setLoad(16'd60, 32'h500, 4'd8);
    chk("R7 mem request raised", memReqValid, 1);
    step(); dropLoad();
    chk("R7 blocked set", loadBlocked, 1);
    chk("R7 blocked seq", blockedSeq, 60);
    memReady = 0; setLoad(16'd70, 32'h500, 4'd8); step(); dropLoad();
    chk("R7 younger blocked ignored", blockedSeq, 60);
    memReady = 0; setLoad(16'd55, 32'h500, 4'd8); step(); dropLoad();
    chk("R7 older blocked replaces", blockedSeq, 55);
    blkClear = 1; step(); blkClear = 0;
    chk("R7 blkClear", loadBlocked, 0);
  endtask

  task automatic testUncache();
    ldUncache = 1; ldAtCommit = 0;
    setLoad(16'd80, 32'h600, 4'd4);
    chk("R8 reschedule code", ldResult, 3);
    chk("R8 no mem request", memReqValid, 0);
    ldAtCommit = 1; #1;
    chk("R8 eligible uncacheable to memory", ldResult, 0);
    chk("R8 eligible mem request", memReqValid, 1);
    dropLoad();
  endtask

  task automatic testSquash();
    doAlloc(16'd200); doWrite(3'd1, 32'h400, 4'd8, 64'hFEDCBA9876543210);
    doAlloc(16'd210); doWrite(3'd2, 32'h408, 4'd8, 64'h0123456789ABCDEF);
    doAlloc(16'd220); doWrite(3'd3, 32'h410, 4'd4, 64'h99887766);
    setLoad(16'd230, 32'h410, 4'd8); step(); dropLoad();
    chk("R4 stall on partial store", stallStoreSeq, 220);
    doSquash(16'd215);
    chk("R11 stall cleared by squash", stalled, 0);
    chk("R11 allocIdx rewound", allocIdx, 3);
    setLoad(16'd230, 32'h410, 4'd8);
    chk("R11 squashed store gone", ldResult, 0);
    ldAddr = 32'h408; #1;
    chk("R11 survivor forwards", ldData, 64'h0123456789ABCDEF);
    ldAddr = 32'h404; ldSize = 4'd4; #1;
    chk("R3 upper word of survivor", ldData, 64'hFEDCBA98);
    dropLoad();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    testReset();
    testFull();
    testForward();
    testStall();
    testBlocked();
    testUncache();
    testSquash();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule